// File: doc/BRIEF.md
# Two-Wire Bus Clock Timing Generator

This block generates the clock line for a master on a two-wire open-drain bus, in the style of SMBus, and watches both lines for bus activity. Phase lengths are counted in overflow ticks from one of several external timer sources. A select field picks the source. The block never drives the clock line high. It asserts a pull-low request and reads back the level that is actually on the wire, so a slower device that stretches the clock delays the next phase.

The same sampled lines feed a START/STOP detector. That detector keeps a busy flag, and an idle-bus detector counted in ticks can clear the flag. The block also makes the reload and count-enable controls for an external low-timeout counter. Shifting data, addressing and acknowledge handling all sit in a neighbouring block. That neighbour uses `phase_strobe` to know when a clock low phase has ended.

Top module: `smb_clk_timer`

## Requirements
- R1: `tick_sel` value k (00, 01, 10, 11) makes `tick_in[k]` the tick source, and in free-running master mode `phase_strobe` repeats every three periods of that source.
- R2: Each clock low phase (`scl_drive_low` = 1) lasts exactly one tick period of the selected source.
- R3: When nobody stretches the clock, each released (high) phase lasts exactly two tick periods, so the high phase is twice the low phase.
- R4: While another device holds the clock line low, the block does not pull low again. The high-phase tick count starts only once the synchronised line reads high, so the sensed high time is at least one tick period.
- R5: A START (SDA falling while SCL is high, seen after two synchroniser flops) pulses `start_det`. It also sets `bus_busy` and clears `bus_free`.
- R6: A STOP (SDA rising while SCL is high) pulses `stop_det` and clears `bus_busy`.
- R7: When `free_det_en` = 1, `bus_busy` clears once SCL and SDA have both read high for more than 10 tick periods. When `free_det_en` = 0, `bus_busy` stays set with both lines high.
- R8: When `lowto_en` = 1, `to_reload` follows a high SCL and `to_count` follows a low SCL. When `lowto_en` = 0, both are 0.
- R9: When `enable` = 0, the clock line is released, `bus_busy` is 0 and all phase and idle counters return to zero.
- R10: `phase_strobe` is a single-cycle pulse in the same cycle that the clock line is released at the end of a low phase.
- R11: When `master_en` = 0, the block never pulls the clock line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Interface enable |
| master_en | input | 1 | Generate the clock as a master |
| free_det_en | input | 1 | Enable the idle-bus timeout |
| lowto_en | input | 1 | Enable the low-timeout counter controls |
| tick_sel | input | SEL_W | Tick source select |
| tick_in | input | NUM_SRC | One-cycle overflow ticks from the external timers |
| scl_in | input | 1 | Raw clock line level |
| sda_in | input | 1 | Raw data line level |
| scl_drive_low | output | 1 | Open-drain pull-low request for the clock line |
| phase_strobe | output | 1 | Pulse at the end of each low phase |
| start_det | output | 1 | START seen on the bus |
| stop_det | output | 1 | STOP seen on the bus |
| bus_busy | output | 1 | Transfer in progress |
| bus_free | output | 1 | Bus is idle |
| to_reload | output | 1 | Reload request for the low-timeout counter |
| to_count | output | 1 | Count enable for the low-timeout counter |

## Verification
The bench uses the default parameters: four tick sources, one low tick, two high ticks, a ten-tick idle limit and two synchroniser stages. It drives the four sources with periods of 5, 6, 7 and 9 cycles. Each period is longer than the synchroniser latency, so the phase lengths come out as exact cycle counts and every select value gives a different, measurable bit period. The ten-tick idle limit on a 5-cycle source puts the idle timeout about 55 cycles after the lines go high, and that window is short enough to probe on both sides.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
   typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} phase_e;

   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/sct_tick_select.sv
module sct_tick_select #(
   parameter int NUM_SRC = 4,
   parameter int SEL_W   = 2
) (
   input  logic [NUM_SRC-1:0] tick_in,
   input  logic [SEL_W-1:0]   sel,
   input  logic               gate,
   output logic               tick_out
);
   logic picked;

   generate
      if (NUM_SRC == 1) begin : g_single
         assign picked = tick_in[0];
      end else begin : g_multi
         always_comb begin
            picked = 1'b0;
            for (int i = 0; i < NUM_SRC; i++) begin
               if (sel == SEL_W'(i)) picked = tick_in[i];
            end
         end
      end
   endgenerate

   assign tick_out = picked & gate;
endmodule

// File: rtl/sct_line_monitor.sv
module sct_line_monitor #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic start_det,
   output logic stop_det
);
   logic [SYNC_STAGES-1:0] scl_q, sda_q;
   logic                   scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_q <= {scl_q[SYNC_STAGES-2:0], scl_in};
         sda_q <= {sda_q[SYNC_STAGES-2:0], sda_in};
         scl_p <= scl_q[SYNC_STAGES-1];
         sda_p <= sda_q[SYNC_STAGES-1];
      end
   end

   assign scl_s     = scl_q[SYNC_STAGES-1];
   assign sda_s     = sda_q[SYNC_STAGES-1];
   assign start_det = enable & scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = enable & scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/sct_phase_gen.sv
module sct_phase_gen
   import sclgen_pkg::*;
#(
   parameter int LOW_TICKS  = 1,
   parameter int HIGH_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   input  logic scl_s,
   output logic drive_low,
   output logic strobe
);
   localparam int CW = cnt_width((LOW_TICKS > HIGH_TICKS) ? LOW_TICKS : HIGH_TICKS);

   phase_e        ph;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_HIGH;
         cnt       <= '0;
         drive_low <= 1'b0;
         strobe    <= 1'b0;
      end else if (!run) begin
         ph        <= PH_HIGH;
         cnt       <= '0;
         drive_low <= 1'b0;
         strobe    <= 1'b0;
      end else begin
         strobe <= 1'b0;
         case (ph)
            PH_HIGH: begin
               if (!scl_s) begin
                  cnt <= '0;
               end else if (tick) begin
                  if (cnt == CW'(HIGH_TICKS - 1)) begin
                     ph        <= PH_LOW;
                     drive_low <= 1'b1;
                     cnt       <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: begin
               if (tick) begin
                  if (cnt == CW'(LOW_TICKS - 1)) begin
                     ph        <= PH_HIGH;
                     drive_low <= 1'b0;
                     strobe    <= 1'b1;
                     cnt       <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/sct_free_timer.sv
module sct_free_timer
   import sclgen_pkg::*;
#(
   parameter int FREE_TICKS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic idle_lines,
   input  logic tick,
   output logic free_to
);
   localparam int FW = cnt_width(FREE_TICKS + 1);

   logic [FW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         free_to <= 1'b0;
      end else if (!arm || !idle_lines) begin
         cnt     <= '0;
         free_to <= 1'b0;
      end else begin
         free_to <= 1'b0;
         if (tick) begin
            if (cnt < FW'(FREE_TICKS)) begin
               cnt <= cnt + 1'b1;
            end else if (cnt == FW'(FREE_TICKS)) begin
               cnt     <= cnt + 1'b1;
               free_to <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/smb_clk_timer.sv
module smb_clk_timer #(
   parameter int NUM_SRC     = 4,
   parameter int SEL_W       = 2,
   parameter int LOW_TICKS   = 1,
   parameter int HIGH_TICKS  = 2,
   parameter int FREE_TICKS  = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               master_en,
   input  logic               free_det_en,
   input  logic               lowto_en,
   input  logic [SEL_W-1:0]   tick_sel,
   input  logic [NUM_SRC-1:0] tick_in,
   input  logic               scl_in,
   input  logic               sda_in,
   output logic               scl_drive_low,
   output logic               phase_strobe,
   output logic               start_det,
   output logic               stop_det,
   output logic               bus_busy,
   output logic               bus_free,
   output logic               to_reload,
   output logic               to_count
);
   generate
      if (NUM_SRC < 1 || NUM_SRC > (1 << SEL_W)) begin : g_bad_src
         $error("NUM_SRC must be between 1 and 2**SEL_W");
      end
      if (LOW_TICKS < 1 || HIGH_TICKS < 1) begin : g_bad_phase
         $error("phase tick counts must be at least 1");
      end
      if (FREE_TICKS < 1) begin : g_bad_free
         $error("FREE_TICKS must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic scl_s, sda_s, tick, free_to;

   sct_tick_select #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
      .tick_in  (tick_in),
      .sel      (tick_sel),
      .gate     (enable & (master_en | free_det_en)),
      .tick_out (tick)
   );

   sct_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   sct_phase_gen #(.LOW_TICKS(LOW_TICKS), .HIGH_TICKS(HIGH_TICKS)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (enable & master_en),
      .tick      (tick),
      .scl_s     (scl_s),
      .drive_low (scl_drive_low),
      .strobe    (phase_strobe)
   );

   sct_free_timer #(.FREE_TICKS(FREE_TICKS)) u_free (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (enable & free_det_en),
      .idle_lines (scl_s & sda_s),
      .tick       (tick),
      .free_to    (free_to)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    bus_busy <= 1'b0;
      else if (!enable)              bus_busy <= 1'b0;
      else if (start_det)            bus_busy <= 1'b1;
      else if (stop_det || free_to)  bus_busy <= 1'b0;
   end

   assign bus_free  = ~bus_busy;
   assign to_reload = enable & lowto_en & scl_s;
   assign to_count  = enable & lowto_en & ~scl_s;
endmodule

// File: rtl/smb_clk_timer_chk.sv
module smb_clk_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic master_en,
   input logic scl_s,
   input logic scl_drive_low,
   input logic phase_strobe,
   input logic start_det,
   input logic stop_det,
   input logic free_to,
   input logic bus_busy,
   input logic bus_free,
   input logic to_reload,
   input logic to_count
);
   a_r4_high_sensed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_drive_low) |-> $past(scl_s));
   a_r5_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && start_det) |=> (bus_busy && !bus_free));
   a_r6_stop_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !bus_busy);
   a_r7_free_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
      free_to |=> !bus_busy);
   a_r8_timeout_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(to_reload && to_count));
   a_r9_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!scl_drive_low && !bus_busy));
   a_r10_strobe_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      phase_strobe |-> ($fell(scl_drive_low) && $onehot0({start_det, stop_det})));
   a_r11_no_drive_as_slave: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |=> !scl_drive_low);
endmodule

bind smb_clk_timer smb_clk_timer_chk i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .enable        (enable),
   .master_en     (master_en),
   .scl_s         (scl_s),
   .scl_drive_low (scl_drive_low),
   .phase_strobe  (phase_strobe),
   .start_det     (start_det),
   .stop_det      (stop_det),
   .free_to       (free_to),
   .bus_busy      (bus_busy),
   .bus_free      (bus_free),
   .to_reload     (to_reload),
   .to_count      (to_count)
);

// File: tb/test_smb_clk_timer.sv
module test_smb_clk_timer;
   localparam int NSRC = 4;
   localparam int PER [NSRC] = '{5, 6, 7, 9};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, master_en = 1'b0, free_det_en = 1'b0, lowto_en = 1'b0;
   logic [1:0] tick_sel = 2'd0;
   logic [NSRC-1:0] tick_in = '0;
   logic bscl = 1'b1, bsda = 1'b1;
   logic scl_drive_low, phase_strobe, start_det, stop_det;
   logic bus_busy, bus_free, to_reload, to_count;
   logic scl_in;
   int   tcnt [NSRC] = '{0, 0, 0, 0};
   int   checks = 0, errors = 0;

   assign scl_in = bscl & ~scl_drive_low;

   always #4 clk = ~clk;

   always @(negedge clk) begin
      for (int i = 0; i < NSRC; i++) begin
         if (tcnt[i] == PER[i] - 1) begin
            tcnt[i] <= 0;
            tick_in[i] <= 1'b1;
         end else begin
            tcnt[i] <= tcnt[i] + 1;
            tick_in[i] <= 1'b0;
         end
      end
   end

   smb_clk_timer i_smb_clk_timer (
      .clk(clk), .rst_n(rst_n), .enable(enable), .master_en(master_en),
      .free_det_en(free_det_en), .lowto_en(lowto_en), .tick_sel(tick_sel),
      .tick_in(tick_in), .scl_in(scl_in), .sda_in(bsda),
      .scl_drive_low(scl_drive_low), .phase_strobe(phase_strobe),
      .start_det(start_det), .stop_det(stop_det), .bus_busy(bus_busy),
      .bus_free(bus_free), .to_reload(to_reload), .to_count(to_count)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_drive(input logic lvl);
      for (int i = 0; i < 500 && scl_drive_low != lvl; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      check(scl_drive_low == 1'b0, "R9 reset drive", scl_drive_low, 0);
      check(bus_busy == 1'b0 && bus_free == 1'b1, "R9 reset busy", bus_busy, 0);
      check(phase_strobe == 1'b0, "R10 reset strobe", phase_strobe, 0);
   endtask

   task automatic t_rate;
      for (int s = 0; s < NSRC; s++) begin
         int n = 0;
         tick_sel = 2'(s);
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            for (int i = 0; i < 500 && !phase_strobe; i++) @(negedge clk);
         end
         do begin
            @(negedge clk);
            n++;
         end while (!phase_strobe && n < 500);
         check(n == 3 * PER[s], $sformatf("R1 strobe period sel=%0d", s), n, 3 * PER[s]);
      end
   endtask

   task automatic t_phase_len;
      int n = 0, m = 0;
      tick_sel = 2'd0;
      wait_drive(1'b0);
      wait_drive(1'b1);
      do begin
         n++;
         @(negedge clk);
      end while (scl_drive_low && n < 500);
      check(n == PER[0], "R2 low phase length", n, PER[0]);
      check(phase_strobe == 1'b1, "R10 strobe at release", phase_strobe, 1);
      @(negedge clk);
      check(phase_strobe == 1'b0, "R10 strobe one cycle", phase_strobe, 0);
      m = 1;
      while (!scl_drive_low && m < 500) begin
         m++;
         @(negedge clk);
      end
      check(m == 2 * PER[0], "R3 high phase length", m, 2 * PER[0]);
   endtask

   task automatic t_stretch;
      int n = 0;
      logic relow = 1'b0;
      tick_sel = 2'd0;
      wait_drive(1'b1);
      bscl = 1'b0;
      wait_drive(1'b0);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (scl_drive_low) relow = 1'b1;
      end
      check(relow == 1'b0, "R4 no pull-low while stretched", relow, 0);
      bscl = 1'b1;
      while (!scl_drive_low && n < 500) begin
         @(negedge clk);
         n++;
      end
      check(n >= PER[0] && n <= 2 * PER[0] + 3, "R4 sensed high time", n, PER[0]);
   endtask

   task automatic t_start_stop;
      master_en = 1'b0;
      bscl = 1'b1; bsda = 1'b1;
      cyc(6);
      bsda = 1'b0;
      cyc(6);
      check(bus_busy == 1'b1, "R5 busy after START", bus_busy, 1);
      check(bus_free == 1'b0, "R5 not free after START", bus_free, 0);
      bsda = 1'b1;
      cyc(6);
      check(bus_busy == 1'b0, "R6 busy cleared by STOP", bus_busy, 0);
      check(bus_free == 1'b1, "R6 free after STOP", bus_free, 1);
   endtask

   task automatic idle_without_stop;
      bscl = 1'b1; bsda = 1'b1;
      cyc(6);
      bsda = 1'b0; cyc(6);
      bscl = 1'b0; cyc(4);
      bsda = 1'b1; cyc(4);
      bscl = 1'b1;
   endtask

   task automatic t_free;
      master_en = 1'b0;
      tick_sel = 2'd0;
      free_det_en = 1'b1;
      idle_without_stop();
      cyc(40);
      check(bus_busy == 1'b1, "R7 busy before free limit", bus_busy, 1);
      cyc(35);
      check(bus_busy == 1'b0, "R7 free timeout clears busy", bus_busy, 0);
      free_det_en = 1'b0;
      idle_without_stop();
      cyc(100);
      check(bus_busy == 1'b1, "R7 no timeout when disabled", bus_busy, 1);
      bscl = 1'b0; cyc(4); bsda = 1'b0; cyc(4); bscl = 1'b1; cyc(4); bsda = 1'b1;
      cyc(6);
      check(bus_busy == 1'b0, "R6 STOP after idle", bus_busy, 0);
   endtask

   task automatic t_lowto;
      master_en = 1'b0;
      lowto_en = 1'b1;
      bscl = 1'b1; cyc(4);
      check(to_reload == 1'b1 && to_count == 1'b0, "R8 reload while high", to_reload, 1);
      bscl = 1'b0; cyc(4);
      check(to_reload == 1'b0 && to_count == 1'b1, "R8 count while low", to_count, 1);
      lowto_en = 1'b0; cyc(2);
      check(to_reload == 1'b0 && to_count == 1'b0, "R8 off when disabled", to_count, 0);
      bscl = 1'b1; cyc(4);
   endtask

   task automatic t_disable;
      logic seen = 1'b0;
      bsda = 1'b0; cyc(6);
      check(bus_busy == 1'b1, "R5 START before disable", bus_busy, 1);
      master_en = 1'b1;
      wait_drive(1'b1);
      enable = 1'b0;
      cyc(2);
      check(scl_drive_low == 1'b0, "R9 released on disable", scl_drive_low, 0);
      check(bus_busy == 1'b0, "R9 busy cleared on disable", bus_busy, 0);
      master_en = 1'b0;
      bsda = 1'b1;
      cyc(4);
      enable = 1'b1;
      master_en = 1'b0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (scl_drive_low) seen = 1'b1;
      end
      check(seen == 1'b0, "R11 no drive without master", seen, 0);
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      enable = 1'b1;
      master_en = 1'b1;
      t_rate();
      t_phase_len();
      t_stretch();
      t_start_stop();
      t_free();
      t_lowto();
      t_disable();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule